// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block gathers sixteen device interrupt lines and presents a single prioritised request, with a 4-bit level, to one processor. Software controls it through two small groups of 32-bit word registers on a plain bus with a word address, separate read and write strobes, and write and read data. The processor group holds a pending word. Each of its bits stands for a priority level: hardware levels sit in bits 0 to 15 and software levels in bits 16 to 31. The master group holds a pending word for device sources, an enable mask whose top bit masks everything, and a target word that records which processor should take undirected interrupts.

Both groups offer write-only companion ports next to their writable word. The processor group has clear and set ports that act on its pending word. The master group has clear and set ports that act on the enable mask. On these ports only the bits written as one change state. A device line at level n sets pending bit n. It also sets the master source bits that a per-level table gives for n. In that table, level 6 maps to the ethernet source at bit 16 and every other level maps to nothing. A request at level n is raised only when pending bit n is set, the enable mask shares a bit with the table entry for n, and the mask-all bit is clear.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pending, enable and target word reads zero, `cpu_req` is low and `cpu_level` is zero.
- R2: `bus_addr[5]` picks the group (0 processor, 1 master) and `bus_addr[4:2]` picks the word. Processor words: 0 pending (read/write), 1 clear, 2 set. Master words: 0 pending (read/write), 1 enable (read/write), 2 clear, 3 set, 4 target. A read returns its data on `bus_rdata` one clock after the edge that samples `bus_rd`.
- R3: A write to a clear port drops exactly the bits written as one (processor clear acts on processor pending, master clear acts on the enable mask). All other bits keep their value.
- R4: A write to a set port raises exactly the bits written as one (processor set acts on processor pending, master set acts on the enable mask). All other bits keep their value.
- R5: Reads of a clear port, a set port or an unmapped word return zero. Writes to unmapped words change no state.
- R6: While device line n is high, processor pending bit n becomes set at the next edge. The master pending word also gains the source bits mapped to n: level 6 maps to bit 16, and every other level maps to no bit.
- R7: When a bus write and a device line act on the same processor pending bit in the same cycle, the bit ends up set.
- R8: `cpu_req` is high, and `cpu_level` holds the highest level n in 1..15 for which pending bit n is set and the enable word shares a bit with the source mask of n. When no level qualifies, `cpu_req` is low and `cpu_level` is zero.
- R9: While enable bit 31 is set, `cpu_req` is low and `cpu_level` is zero, whatever else is pending and enabled.
- R10: The target word stores the low 4 bits written to it and reads back as those bits, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address: bit 5 picks the group, bits 4:2 pick the word |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| dev_irq | input | 16 | Device interrupt lines, one per level |
| cpu_level | output | 4 | Level of the highest qualifying interrupt |
| cpu_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. The stimulus keeps to this because it issues each bus access as its own one-cycle task. The assertions that check the clear ports also assume that no device line is high during that cycle. The stimulus raises a device line only in deliberate pulses. The single collision test, which drives a device line together with a clear write, breaks only the clear-port assertion's guard condition, so that assertion is not evaluated there.

// File: rtl/lvl_irq_pkg.sv
// Package: shared constants and the level-to-source mapping of the
// interrupt controller. Assumes a 32-bit data word.
package lvl_irq_pkg;

    localparam int WORD_W      = 32;
    localparam int MASK_ALL_B  = 31;
    localparam int ENET_SRC_B  = 16;
    localparam int ENET_LEVEL  = 6;

    // Word offsets inside the processor group
    typedef enum logic [2:0] {
        CPU_PEND = 3'd0,
        CPU_CLR  = 3'd1,
        CPU_SET  = 3'd2
    } cpu_ofs_e;

    // Word offsets inside the master group
    typedef enum logic [2:0] {
        MST_PEND = 3'd0,
        MST_EN   = 3'd1,
        MST_CLR  = 3'd2,
        MST_SET  = 3'd3,
        MST_TGT  = 3'd4
    } mst_ofs_e;

    // Source mask that a device line at the given level stands for
    function automatic logic [WORD_W-1:0] src_mask(input int lvl);
        logic [WORD_W-1:0] m;
        m = '0;
        if (lvl == ENET_LEVEL) m[ENET_SRC_B] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_cpu_bank.sv
// Module: processor register group. Holds the pending word, whose bits
// stand for priority levels. Offers a read/write pending word and
// write-only clear/set ports. Device lines override bus writes bit by bit.
// Assumes NUM_LVL <= DATA_W and that read and write strobes are exclusive.
module irq_cpu_bank #(
    parameter int DATA_W  = 32,
    parameter int NUM_LVL = 16,
    parameter int OFS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_LVL-1:0] dev_irq,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] pend_o
);
    import lvl_irq_pkg::*;

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] pend_d;
    logic [DATA_W-1:0] dev_ext;

    assign dev_ext = DATA_W'(dev_irq);

    // Next pending value: bus effect first, then device lines win
    always_comb begin
        pend_d = pend_q;
        if (wr_en) begin
            case (ofs)
                OFS_W'(CPU_PEND): pend_d = wr_data;
                OFS_W'(CPU_CLR):  pend_d = pend_q & ~wr_data;
                OFS_W'(CPU_SET):  pend_d = pend_q | wr_data;
                default:          pend_d = pend_q;
            endcase
        end
        pend_d = pend_d | dev_ext;
    end

    // Pending word register
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Read mux: only the pending word is readable
    always_comb begin
        rd_word = '0;
        if (ofs == OFS_W'(CPU_PEND)) rd_word = pend_q;
    end

    assign pend_o = pend_q;

    // A high device line leaves its pending bit set one edge later
    assert_dev_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q[NUM_LVL-1:0] & $past(dev_irq)) == $past(dev_irq)));

    // A clear write with quiet device lines raises no bit and drops written ones
    assert_clr_only_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_W'(CPU_CLR) && dev_irq == '0) |=>
        (((pend_q & ~$past(pend_q)) == '0) && ((pend_q & $past(wr_data)) == '0)));

    // A set write drops no bit
    assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_W'(CPU_SET)) |=> (($past(pend_q) & ~pend_q) == '0));

endmodule

// File: rtl/irq_master_bank.sv
// Module: master register group. Holds the source pending word, the
// enable mask with its clear/set ports, and the undirected target word.
// Device lines feed mapped source bits into the pending word.
// Assumes the strobes are exclusive and DATA_W is at least 32.
module irq_master_bank #(
    parameter int DATA_W  = 32,
    parameter int NUM_LVL = 16,
    parameter int OFS_W   = 3,
    parameter int TGT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_LVL-1:0] dev_irq,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] en_o
);
    import lvl_irq_pkg::*;

    logic [DATA_W-1:0] pend_q, pend_d;
    logic [DATA_W-1:0] en_q, en_d;
    logic [TGT_W-1:0]  tgt_q, tgt_d;
    logic [DATA_W-1:0] dev_src;

    // Union of the source masks of every active device line
    always_comb begin
        dev_src = '0;
        for (int n = 0; n < NUM_LVL; n++) begin
            if (dev_irq[n]) dev_src = dev_src | DATA_W'(src_mask(n));
        end
    end

    // Next state of all three words from the bus, device sources last
    always_comb begin
        pend_d = pend_q;
        en_d   = en_q;
        tgt_d  = tgt_q;
        if (wr_en) begin
            case (ofs)
                OFS_W'(MST_PEND): pend_d = wr_data;
                OFS_W'(MST_EN):   en_d   = wr_data;
                OFS_W'(MST_CLR):  en_d   = en_q & ~wr_data;
                OFS_W'(MST_SET):  en_d   = en_q | wr_data;
                OFS_W'(MST_TGT):  tgt_d  = wr_data[TGT_W-1:0];
                default: ;
            endcase
        end
        pend_d = pend_d | dev_src;
    end

    // Master state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            tgt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            tgt_q  <= tgt_d;
        end
    end

    // Read mux: write-only and unmapped words read zero
    always_comb begin
        case (ofs)
            OFS_W'(MST_PEND): rd_word = pend_q;
            OFS_W'(MST_EN):   rd_word = en_q;
            OFS_W'(MST_TGT):  rd_word = DATA_W'(tgt_q);
            default:          rd_word = '0;
        endcase
    end

    assign en_o = en_q;

    // Set port raises the written bits and drops none
    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_W'(MST_SET)) |=>
        ((($past(en_q) & ~en_q) == '0) && ((en_q & $past(wr_data)) == $past(wr_data))));

    // Clear port drops the written bits and raises none
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_W'(MST_CLR)) |=>
        (((en_q & ~$past(en_q)) == '0) && ((en_q & $past(wr_data)) == '0)));

    // The enable word stays put unless a write hits one of its three offsets
    assert_en_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (ofs == OFS_W'(MST_EN) || ofs == OFS_W'(MST_CLR) || ofs == OFS_W'(MST_SET)))
        |=> $stable(en_q));

endmodule

// File: rtl/irq_level_pick.sv
// Module: qualifies each pending level against the enable mask through
// its source mask and reports the highest qualifying level. Level 0
// means no interrupt. Enable bit 31 masks every level.
module irq_level_pick #(
    parameter int DATA_W  = 32,
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_pend,
    input  logic [DATA_W-1:0] en,
    output logic [LVL_W-1:0]  level,
    output logic              req
);
    import lvl_irq_pkg::*;

    logic [NUM_LVL-1:0] qual;

    assign qual[0] = 1'b0;

    // One qualifier per level
    for (genvar g = 1; g < NUM_LVL; g++) begin : g_qual
        localparam logic [DATA_W-1:0] SRC = DATA_W'(src_mask(g));
        assign qual[g] = cpu_pend[g] && ((en & SRC) != '0) && !en[MASK_ALL_B];
    end

    // Priority pick: the highest qualifying level wins
    always_comb begin
        level = '0;
        for (int n = 1; n < NUM_LVL; n++) begin
            if (qual[n]) level = LVL_W'(n);
        end
    end

    assign req = |qual;

    // Mask-all keeps the request down
    assert_maskall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en[MASK_ALL_B] |-> (!req && level == '0));

    // A request always names a pending level
    assert_req_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (level != '0 && cpu_pend[level]));

endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: top of the two-level interrupt controller. Decodes the word
// bus into the processor and master groups, registers the read data and
// drives the level/request pair to one processor.
// Assumes bus_rd and bus_wr are never high together.
module lvl_irq_ctrl #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int NUM_LVL = 16,
    parameter int TGT_W   = 4,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_LVL-1:0] dev_irq,
    output logic [LVL_W-1:0]   cpu_level,
    output logic               cpu_req
);
    localparam int GRP_B = ADDR_W - 1;
    localparam int OFS_W = ADDR_W - 3;

    logic              grp_mst;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] cpu_rd, mst_rd, cpu_pend, mst_en;
    logic [DATA_W-1:0] rdata_q;

    assign grp_mst = bus_addr[GRP_B];
    assign ofs     = bus_addr[GRP_B-1:2];

    irq_cpu_bank #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .OFS_W(OFS_W)) cpu_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && !grp_mst), .ofs(ofs),
        .wr_data(bus_wdata), .dev_irq(dev_irq), .rd_word(cpu_rd), .pend_o(cpu_pend)
    );

    irq_master_bank #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .OFS_W(OFS_W), .TGT_W(TGT_W)) mst_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && grp_mst), .ofs(ofs),
        .wr_data(bus_wdata), .dev_irq(dev_irq), .rd_word(mst_rd), .en_o(mst_en)
    );

    irq_level_pick #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) pick_i (
        .clk(clk), .rst_n(rst_n), .cpu_pend(cpu_pend), .en(mst_en),
        .level(cpu_level), .req(cpu_req)
    );

    // Read data register, loaded from the selected group on a read
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= grp_mst ? mst_rd : cpu_rd;
    end

    assign bus_rdata = rdata_q;

    // Reset leaves no request and zero read data
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_req && cpu_level == '0 && bus_rdata == '0));

    // Read data only moves on a read
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] dev_irq = '0;
    logic [3:0]  cpu_level;
    logic        cpu_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_irq(dev_irq), .cpu_level(cpu_level), .cpu_req(cpu_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard when read data has been loaded
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) check("R2 unexpected read", 32'h1, 32'h0);
            else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_dev(logic [15:0] v);
        @(negedge clk);
        dev_irq = v;
        @(negedge clk);
        dev_irq = '0;
    endtask

    task automatic chk_out(string tag, logic exp_req, logic [3:0] exp_lvl);
        check(tag, {27'b0, cpu_req, cpu_level}, {27'b0, exp_req, exp_lvl});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_out("R1 outputs after reset", 1'b0, 4'd0);
        rd(6'h00, 32'h0, "R1 cpu pending reset");
        rd(6'h24, 32'h0, "R1 enable reset");
        rd(6'h30, 32'h0, "R1 target reset");
        // R2/R3/R4/R5 processor group
        wr(6'h00, 32'hA5A5_0F0F);
        rd(6'h00, 32'hA5A5_0F0F, "R2 cpu pending rw");
        wr(6'h04, 32'h0000_0F00);
        rd(6'h00, 32'hA5A5_000F, "R3 cpu clear");
        wr(6'h08, 32'h0000_00F0);
        rd(6'h00, 32'hA5A5_00FF, "R4 cpu set");
        rd(6'h04, 32'h0, "R5 cpu clear reads zero");
        rd(6'h08, 32'h0, "R5 cpu set reads zero");
        wr(6'h0C, 32'hFFFF_FFFF);
        rd(6'h00, 32'hA5A5_00FF, "R5 cpu unmapped write ignored");
        rd(6'h0C, 32'h0, "R5 cpu unmapped reads zero");
        wr(6'h00, 32'h0);
        // master group
        wr(6'h24, 32'h0000_1234);
        rd(6'h24, 32'h0000_1234, "R2 enable rw");
        wr(6'h28, 32'h0000_0204);
        rd(6'h24, 32'h0000_1030, "R3 enable clear");
        wr(6'h2C, 32'h0001_0001);
        rd(6'h24, 32'h0001_1031, "R4 enable set");
        rd(6'h28, 32'h0, "R5 master clear reads zero");
        rd(6'h2C, 32'h0, "R5 master set reads zero");
        wr(6'h34, 32'hFFFF_FFFF);
        rd(6'h24, 32'h0001_1031, "R5 master unmapped write ignored");
        rd(6'h34, 32'h0, "R5 master unmapped reads zero");
        wr(6'h30, 32'hFFFF_FFF7);
        rd(6'h30, 32'h0000_0007, "R10 target low bits");
        wr(6'h20, 32'h4000_0001);
        rd(6'h20, 32'h4000_0001, "R2 master pending rw");
        wr(6'h20, 32'h0);
        chk_out("R8 nothing pending", 1'b0, 4'd0);
        // R6/R8 device line at level 6
        pulse_dev(16'h0040);
        chk_out("R8 level 6 request", 1'b1, 4'd6);
        rd(6'h00, 32'h0000_0040, "R6 cpu pending from device");
        rd(6'h20, 32'h0001_0000, "R6 ethernet source bit");
        pulse_dev(16'h0008);
        rd(6'h20, 32'h0001_0000, "R6 unmapped level adds no source");
        rd(6'h00, 32'h0000_0048, "R6 level 3 pending");
        chk_out("R8 level 3 not enabled, 6 still wins", 1'b1, 4'd6);
        // R9 mask-all
        wr(6'h2C, 32'h8000_0000);
        chk_out("R9 mask-all blocks", 1'b0, 4'd0);
        wr(6'h28, 32'h8000_0000);
        chk_out("R9 mask-all lifted", 1'b1, 4'd6);
        // R8 enable and pending gate
        wr(6'h28, 32'h0001_0000);
        chk_out("R8 source disabled", 1'b0, 4'd0);
        wr(6'h2C, 32'h0001_0000);
        chk_out("R8 source re-enabled", 1'b1, 4'd6);
        wr(6'h04, 32'h0000_0040);
        chk_out("R8 pending cleared", 1'b0, 4'd0);
        rd(6'h00, 32'h0000_0008, "R3 only level 6 cleared");
        // R7 device beats bus clear in the same cycle
        @(negedge clk);
        bus_addr = 6'h04; bus_wdata = 32'h0000_0008; bus_wr = 1'b1; dev_irq = 16'h0008;
        @(negedge clk);
        bus_wr = 1'b0; dev_irq = '0;
        rd(6'h00, 32'h0000_0008, "R7 device wins over clear");
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h0; bus_wr = 1'b1; dev_irq = 16'h0040;
        @(negedge clk);
        bus_wr = 1'b0; dev_irq = '0;
        rd(6'h00, 32'h0000_0040, "R7 device wins over pending write");
        chk_out("R7 request from surviving bit", 1'b1, 4'd6);
        // R8 a level with an empty source mask never requests
        wr(6'h04, 32'h0000_0040);
        wr(6'h08, 32'h0000_0200);
        wr(6'h24, 32'h7FFF_FFFF);
        chk_out("R8 level 9 has no source", 1'b0, 4'd0);
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb_q.size()), 32'h0);
        finish_run();
    end
endmodule